// File: doc/BRIEF.md
# SPI Register Bank Slave

This block is a mode 0 SPI slave that lets a host read and write a bank of sixteen 8-bit registers belonging to a timekeeping device. The bank sits outside this block. The slave produces a one-cycle write strobe with address and data for every byte the host writes. For reads, it presents a read address and takes the register value back through a combinational read port.

Each transaction is framed by a chip select that is active high. The first byte is a command. Bit 4 of the command is a marker and must be set. Bit 7 chooses a read when it is 1 and a write when it is 0. Bits 3..0 give the first register to access. Every following byte moves one register. The register pointer steps up by one after each byte and wraps from 0xF to 0x0, so a single burst can cover a run of consecutive registers, such as the seven time-of-day registers. The SCK, chip select and MOSI pins reach the system clock domain through two-flop synchronisers. SCK must therefore stay high and low for several system clocks at a time.

Top module: `spi_regfile_slave`

## Requirements
- R1: The slave responds only while `spi_cs` is 1. When `spi_cs` returns to 0, `miso_oe` goes low, no write strobe follows, and the next transaction starts again with a command byte.
- R2: In the command byte, bit 4 = 1 marks a valid access, bit 7 = 1 selects a read and bit 7 = 0 selects a write, and bits 3..0 give the start register address.
- R3: If a command byte has bit 4 = 0, the rest of the transaction is ignored. The slave issues no write strobes and keeps `miso_oe` at 0 until chip select falls.
- R4: In a write transaction, each complete data byte produces exactly one single-cycle `wr_en` pulse, with `wr_addr` set to the current pointer and `wr_data` set to the received byte.
- R5: The register pointer steps by one after every data byte and wraps from 0xF to 0x0.
- R6: In a read transaction, `rd_data` at `rd_addr` is captured at the SCK falling edge that ends the previous byte and shifted out on `spi_miso` MSB first, one bit per falling edge. `miso_oe` is 0 during the command byte and 1 from that first capture until chip select falls.
- R7: MOSI is sampled on the rising SCK edge, MSB first.
- R8: While reset is asserted, `wr_en` and `miso_oe` are 0.
- R9: If chip select falls before all 8 bits of a byte have arrived, that byte produces no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| wr_en | output | 1 | Single-cycle register write strobe |
| wr_addr | output | 4 | Register address for the write |
| wr_data | output | 8 | Register data for the write |
| rd_addr | output | 4 | Register address being read |
| rd_data | input | 8 | Register value at `rd_addr` |

## Verification
The hardest case to reach is the pointer wrapping past 0xF in the middle of a burst while the correct data keeps flowing in both directions. The stimulus table contains a write burst starting at 0xE and reads starting at 0xD and at 0x0 that run through all sixteen registers and one more byte. Every value returned is compared against a model the bench keeps separately. A chip select that falls after five bits of a write data byte, followed by a read of the same register, shows that a partial byte leaves the register unchanged. Commands with the marker bit cleared are sent in both directions, and the bench confirms that no strobe appears and the output driver stays off.

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          miso_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int BCW = $clog2(DW);
  localparam int MARK = 4;
  localparam int RDB = DW - 1;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_SKIP} state_t;

  logic [2:0]     sck_q;
  logic [1:0]     cs_q, mosi_q;
  logic           cs_s, mosi_s, sck_r, sck_f;
  state_t         state;
  logic [BCW-1:0] bitcnt;
  logic [DW-2:0]  rx;
  logic [DW-1:0]  tx, byte_in;
  logic [AW-1:0]  ptr;
  logic           load_pend, rd_live;

  assign cs_s    = cs_q[1];
  assign mosi_s  = mosi_q[1];
  assign sck_r   = sck_q[1] & ~sck_q[2];
  assign sck_f   = ~sck_q[1] & sck_q[2];
  assign byte_in = {rx, mosi_s};
  assign rd_addr = ptr;
  assign spi_miso = tx[DW-1];
  assign miso_oe  = cs_s & rd_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '0;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      cs_q   <= {cs_q[0], spi_cs};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CMD;
      bitcnt    <= '0;
      rx        <= '0;
      tx        <= '0;
      ptr       <= '0;
      load_pend <= 1'b0;
      rd_live   <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!cs_s) begin
        state     <= ST_CMD;
        bitcnt    <= '0;
        load_pend <= 1'b0;
        rd_live   <= 1'b0;
      end else begin
        if (sck_r) begin
          rx     <= byte_in[DW-2:0];
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == BCW'(DW - 1)) begin
            unique case (state)
              ST_CMD: begin
                if (byte_in[MARK]) begin
                  state     <= byte_in[RDB] ? ST_RD : ST_WR;
                  ptr       <= byte_in[AW-1:0];
                  load_pend <= byte_in[RDB];
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_WR: begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= byte_in;
                ptr     <= ptr + 1'b1;
              end
              ST_RD:   load_pend <= 1'b1;
              default: ;
            endcase
          end
        end
        if (sck_f) begin
          if (load_pend) begin
            tx        <= rd_data;
            ptr       <= ptr + 1'b1;
            load_pend <= 1'b0;
            rd_live   <= 1'b1;
          end else begin
            tx <= {tx[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_wr_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cs_s));
  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!wr_en && !miso_oe));
  assert_oe_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(sck_f));
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == wr_addr + 1'b1));
endmodule

// File: tb/spi_regfile_slave_test.sv
`timescale 1ns/1ps
module spi_regfile_slave_test;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  logic [7:0] bank [16];
  logic [7:0] expb [16];
  logic [3:0] log_a [64];
  logic [7:0] log_d [64];
  int wr_total = 0;
  int errs = 0, checks = 0;
  logic [7:0] rxb [32];
  int oe_cmd, oe_data;

  always #2 clk = ~clk;

  spi_regfile_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs(cs), .spi_mosi(mosi),
    .spi_miso(miso), .miso_oe(miso_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign rd_data = bank[rd_addr];

  always @(posedge clk) begin
    if (rst_n && wr_en) begin
      bank[wr_addr] <= wr_data;
      log_a[wr_total[5:0]] <= wr_addr;
      log_d[wr_total[5:0]] <= wr_data;
      wr_total <= wr_total + 1;
    end
  end

  // {command, byte count, data seed}
  localparam logic [23:0] VEC [8] = '{
    {8'h12, 8'd7,  8'h30},
    {8'h92, 8'd7,  8'h00},
    {8'h1E, 8'd4,  8'hA5},
    {8'h9D, 8'd5,  8'h00},
    {8'h02, 8'd3,  8'h55},
    {8'h82, 8'd2,  8'h00},
    {8'h90, 8'd17, 8'h00},
    {8'h17, 8'd1,  8'h6C}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  task automatic shift_bits(input logic [7:0] d, input int n,
                            output logic [7:0] r, inout int oe_cnt);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = d[i];
      #HALF;
      r[i] = miso;
      if (miso_oe) oe_cnt++;
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int len, input logic [7:0] seed);
    logic [7:0] r;
    oe_cmd = 0;
    oe_data = 0;
    cs = 1'b1;
    #HALF;
    shift_bits(cmd, 8, r, oe_cmd);
    for (int b = 0; b < len; b++) begin
      shift_bits(pat(seed, b), 8, r, oe_data);
      rxb[b] = r;
    end
    #HALF;
    cs = 1'b0;
    #HALF;
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      bank[i] = 8'(i * 17 + 3);
      expb[i] = 8'(i * 17 + 3);
    end
    #1;
    #20;
    // R8: reset state
    chk(wr_en == 1'b0, "R8", "wr_en in reset", wr_en, 0);
    chk(miso_oe == 1'b0, "R8", "miso_oe in reset", miso_oe, 0);
    rst_n = 1'b1;
    #40;

    for (int v = 0; v < 8; v++) begin
      logic [7:0] cmd;
      int len, start;
      cmd = VEC[v][23:16];
      len = int'(VEC[v][15:8]);
      start = int'(cmd[3:0]);
      begin
        int w0;
        w0 = wr_total;
        xfer(cmd, len, VEC[v][7:0]);
        chk(oe_cmd == 0, "R6", "miso_oe during command", oe_cmd, 0);
        chk(miso_oe == 1'b0, "R1", "miso_oe after cs low", miso_oe, 0);
        if (!cmd[4]) begin
          // R3: marker bit clear
          chk(wr_total == w0, "R3", "writes after unmarked command", wr_total - w0, 0);
          chk(oe_data == 0, "R3", "miso_oe after unmarked command", oe_data, 0);
        end else if (!cmd[7]) begin
          // R2 R4 R5 R7: write burst
          chk(wr_total - w0 == len, "R4", "write strobe count", wr_total - w0, len);
          for (int b = 0; b < len; b++) begin
            logic [3:0] a;
            a = 4'(start + b);
            chk(log_a[6'(w0 + b)] == a, "R5", "write address", log_a[6'(w0 + b)], a);
            chk(log_d[6'(w0 + b)] == pat(VEC[v][7:0], b), "R7", "write data",
                log_d[6'(w0 + b)], pat(VEC[v][7:0], b));
            expb[a] = pat(VEC[v][7:0], b);
          end
        end else begin
          // R2 R5 R6: read burst
          chk(wr_total == w0, "R2", "writes during read", wr_total - w0, 0);
          chk(oe_data == 8 * len, "R6", "miso_oe bits during data", oe_data, 8 * len);
          for (int b = 0; b < len; b++) begin
            logic [3:0] a;
            a = 4'(start + b);
            chk(rxb[b] == expb[a], "R6", "read data", rxb[b], expb[a]);
          end
        end
      end
    end

    // R9: cs drops after 5 bits of a write data byte to register 3
    begin
      logic [7:0] r;
      int w0, n;
      w0 = wr_total;
      n = 0;
      cs = 1'b1;
      #HALF;
      shift_bits(8'h13, 8, r, n);
      shift_bits(8'hFF, 5, r, n);
      #HALF;
      cs = 1'b0;
      #HALF;
      chk(wr_total == w0, "R9", "strobe after partial byte", wr_total - w0, 0);
      // R1: next frame starts with a command again
      xfer(8'h93, 1, 8'h00);
      chk(rxb[0] == expb[3], "R9", "register after partial byte", rxb[0], expb[3]);
      chk(wr_total == w0, "R1", "writes in new frame", wr_total - w0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule